// File: doc/BRIEF.md
# Packet Interrupt Coalescing Counter

This block sits next to a DMA channel and cuts down how often the processor is interrupted. Each finished packet arrives as a one-cycle pulse, and the block adds it to a pending-packet count. An interrupt is raised as soon as either of two conditions is met. The first is that the pending count has climbed to a programmed 8-bit threshold. The second is that packets are pending and no new packet has arrived for a programmed wait time.

Software reaches the block through a small register port. It reads the pending count and issues a decrement command once for each packet it has serviced. It also programs the threshold and the wait bound, acknowledges events in a status register and masks them through an enable register. The status and enable registers use the same bit layout. The wait time is counted in prescaled ticks of `PRESCALE` clocks each.

All pins are plain control and status signals. The register port has no handshake: a write takes effect at the clock edge where `reg_wr_i` is high, and `reg_rdata_o` shows the register selected by `reg_addr_i` within the same cycle.

Top module: `pkt_coalesce`

## Requirements
- R1: Each clock edge with `pkt_done_i` high adds one to the pending count. The count saturates at 255 and never wraps.
- R2: If a packet pulse and a decrement command arrive in the same cycle while the count is non-zero, the count stays the same.
- R3: Writing any data to address 1 is a decrement command, which lowers the count by one. A decrement while the count is zero does nothing. A pulse together with a decrement at zero gives a count of 1.
- R4: Status bit 3 (threshold) is set on the clock edge where the count steps from below a non-zero threshold to at or above it. Further packets after that crossing do not set it again.
- R5: A threshold of zero never sets status bit 3.
- R6: Status bit 2 (packet done) is set on every packet pulse.
- R7: The wait timer runs while the count is non-zero and restarts on every packet. Status bit 4 (wait bound) is set exactly bound×PRESCALE clock edges after the last packet edge.
- R8: A wait bound of zero never sets status bit 4.
- R9: When the count returns to zero, the wait timer stops and clears. A later packet then gets a full, fresh wait window.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear keeps the bit set.
- R11: `irq_o` is high exactly when some status bit and the enable bit in the same position are both 1. The enable register uses the status layout: only bits 2, 3 and 4 can be written, and the other bits read 0.
- R12: Register map:
  - address 0: count, read-only.
  - address 1: decrement command.
  - address 2: threshold, 8 bits.
  - address 3: wait bound, 16 bits.
  - address 4: status.
  - address 5: enable.

  Every register resets to 0. Bits wider than a register's width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_done_i | input | 1 | One-cycle pulse per completed packet |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (3) | Register address |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| reg_rdata_o | output | DATA_W (32) | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Coalesced interrupt request |

## Verification
The bench builds the block with `PRESCALE` set to 4 and leaves the other parameters at their defaults. With a wait bound of 3, a wait-bound event then falls due after twelve edges instead of several thousand. The bench can therefore check, at the exact cycle, the edge just before the event and the edge it fires on, a restart caused by a second packet, and the fresh window after the count drains to zero. Keeping the 8-bit count width means 260 back-to-back pulses are enough to show saturation at 255.

// File: rtl/pkt_coal_pkg.sv
package pkt_coal_pkg;
  // register addresses
  localparam int A_CNT   = 0;
  localparam int A_DEC   = 1;
  localparam int A_THR   = 2;
  localparam int A_BOUND = 3;
  localparam int A_STAT  = 4;
  localparam int A_EN    = 5;
  // status / enable layout
  localparam int ST_W    = 8;
  localparam int B_PKT   = 2;
  localparam int B_THR   = 3;
  localparam int B_WAIT  = 4;
  localparam logic [ST_W-1:0] ST_USED = 8'b0001_1100;
endpackage

// File: rtl/pkt_coal_count.sv
module pkt_coal_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             thr_hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_ok;

  assign dec_ok = dec_i && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && !dec_ok) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (dec_ok && !inc_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // crossing event: below threshold now, at or above after this edge
  assign thr_hit_o = (thr_i != '0) && (cnt_q < thr_i) && (cnt_d >= thr_i);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/pkt_coal_wait.sv
module pkt_coal_wait #(
  parameter int WB_W     = 16,
  parameter int PRESCALE = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pkt_i,
  input  logic            active_i,
  input  logic [WB_W-1:0] bound_i,
  output logic            fire_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic            restart, running, tick;
  logic [WB_W-1:0] wait_q;
  logic            expired_q;

  assign restart = pkt_i || !active_i;
  assign running = !restart && !expired_q && (bound_i != '0);

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (running) pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign fire_o = running && tick && (({1'b0, wait_q} + 1'b1) >= {1'b0, bound_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q    <= '0;
      expired_q <= 1'b0;
    end else if (restart) begin
      wait_q    <= '0;
      expired_q <= 1'b0;
    end else if (running && tick) begin
      wait_q <= wait_q + 1'b1;
      if (fire_o) expired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pkt_coal_irq.sv
module pkt_coal_irq
  import pkt_coal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_i,
  input  logic            clr_we_i,
  input  logic [ST_W-1:0] clr_i,
  input  logic            en_we_i,
  input  logic [ST_W-1:0] en_i,
  output logic [ST_W-1:0] status_o,
  output logic [ST_W-1:0] enable_o,
  output logic            irq_o
);
  logic [ST_W-1:0] status_q, enable_q, clr_mask;

  assign clr_mask = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= ((status_q & ~clr_mask) | set_i) & ST_USED;
      if (en_we_i) enable_q <= en_i & ST_USED;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = |(status_q & enable_q);
endmodule

// File: rtl/pkt_coalesce.sv
module pkt_coalesce
  import pkt_coal_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WB_W     = 16,
  parameter int PRESCALE = 1024,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] thr_q, cnt;
  logic [WB_W-1:0]  bound_q;
  logic             dec_cmd, thr_hit, wait_fire;
  logic             wr_thr, wr_bound, wr_stat, wr_en;
  logic [ST_W-1:0]  set_vec, status, enable;
  logic             unused_wdata;

  assign dec_cmd  = reg_wr_i && (reg_addr_i == ADDR_W'(A_DEC));
  assign wr_thr   = reg_wr_i && (reg_addr_i == ADDR_W'(A_THR));
  assign wr_bound = reg_wr_i && (reg_addr_i == ADDR_W'(A_BOUND));
  assign wr_stat  = reg_wr_i && (reg_addr_i == ADDR_W'(A_STAT));
  assign wr_en    = reg_wr_i && (reg_addr_i == ADDR_W'(A_EN));
  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      bound_q <= '0;
    end else begin
      if (wr_thr)   thr_q   <= reg_wdata_i[CNT_W-1:0];
      if (wr_bound) bound_q <= reg_wdata_i[WB_W-1:0];
    end
  end

  pkt_coal_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc_i(pkt_done_i), .dec_i(dec_cmd),
    .thr_i(thr_q), .cnt_o(cnt), .thr_hit_o(thr_hit)
  );

  pkt_coal_wait #(.WB_W(WB_W), .PRESCALE(PRESCALE)) u_wait (
    .clk(clk), .rst_n(rst_n), .pkt_i(pkt_done_i), .active_i(cnt != '0),
    .bound_i(bound_q), .fire_o(wait_fire)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_PKT]  = pkt_done_i;
    set_vec[B_THR]  = thr_hit;
    set_vec[B_WAIT] = wait_fire;
  end

  pkt_coal_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec),
    .clr_we_i(wr_stat), .clr_i(reg_wdata_i[ST_W-1:0]),
    .en_we_i(wr_en), .en_i(reg_wdata_i[ST_W-1:0]),
    .status_o(status), .enable_o(enable), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(A_CNT):   reg_rdata_o = DATA_W'(cnt);
      ADDR_W'(A_THR):   reg_rdata_o = DATA_W'(thr_q);
      ADDR_W'(A_BOUND): reg_rdata_o = DATA_W'(bound_q);
      ADDR_W'(A_STAT):  reg_rdata_o = DATA_W'(status);
      ADDR_W'(A_EN):    reg_rdata_o = DATA_W'(enable);
      default:          reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pkt_coal_chk.sv
module pkt_coal_chk #(
  parameter int CNT_W = 8,
  parameter int WB_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_i,
  input logic             dec_cmd,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] thr,
  input logic [WB_W-1:0]  bound,
  input logic [7:0]       status
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_i && !dec_cmd && cnt != CMAX) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_i && !dec_cmd && cnt == CMAX) |=> cnt == CMAX);
  assert_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_i && dec_cmd && cnt != '0) |=> cnt == $past(cnt));
  assert_dec_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_cmd && !pkt_i && cnt == '0) |=> cnt == '0);
  assert_thr_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0 && !status[3]) |=> !status[3]);
  assert_pktdone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_i |=> status[2]);
  assert_bound_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bound == '0 && !status[4]) |=> !status[4]);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !status[4]) |=> !status[4]);
endmodule

bind pkt_coalesce pkt_coal_chk #(.CNT_W(CNT_W), .WB_W(WB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_i(pkt_done_i), .dec_cmd(dec_cmd),
  .cnt(cnt), .thr(thr_q), .bound(bound_q), .status(status)
);

// File: tb/pkt_coalesce_bench.sv
`timescale 1ns/100ps
module pkt_coalesce_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  pkt_coalesce #(.PRESCALE(4)) u_pkt_coalesce (
    .clk(clk), .rst_n(rst_n), .pkt_done_i(pkt), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); pkt = 1'b1;
    repeat (n) @(negedge clk);
    pkt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    logic [31:0] c;
    rd_reg(3'd0, c);
    for (int i = 0; i < int'(c); i++) wr_reg(3'd1, 0);
    wr_reg(3'd4, 32'hFF);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), v); check("R12 reset value", v, 0);
    end
    check("R11 irq after reset", {31'b0, irq}, 0);
    wr_reg(3'd2, 32'h1FF); rd_reg(3'd2, v); check("R12 threshold width", v, 32'hFF);
    wr_reg(3'd2, 0);
  endtask

  task automatic t_saturate();
    pulse(260); rd_reg(3'd0, v); check("R1 saturate at 255", v, 255);
    drain(); rd_reg(3'd0, v); check("R3 drained", v, 0);
    wr_reg(3'd1, 0); rd_reg(3'd0, v); check("R3 decrement at zero", v, 0);
  endtask

  task automatic t_same_cycle();
    pulse(2); rd_reg(3'd0, v); check("R1 two pulses", v, 2);
    @(negedge clk); pkt = 1'b1; wr = 1'b1; addr = 3'd1;
    @(negedge clk); pkt = 1'b0; wr = 1'b0;
    rd_reg(3'd0, v); check("R2 pulse with decrement", v, 2);
    wr_reg(3'd1, 0); rd_reg(3'd0, v); check("R3 decrement by one", v, 1);
    drain();
    @(negedge clk); pkt = 1'b1; wr = 1'b1; addr = 3'd1;
    @(negedge clk); pkt = 1'b0; wr = 1'b0;
    rd_reg(3'd0, v); check("R3 pulse with decrement at zero", v, 1);
    drain();
  endtask

  task automatic t_threshold();
    wr_reg(3'd2, 3);
    pulse(2); rd_reg(3'd4, v); check("R4 below threshold", v & 32'h8, 0);
    check("R6 packet done set", v & 32'h4, 32'h4);
    pulse(1); rd_reg(3'd4, v); check("R4 threshold reached", v & 32'h8, 32'h8);
    wr_reg(3'd4, 32'h08); rd_reg(3'd4, v); check("R10 W1C clears only bit 3", v, 32'h4);
    pulse(1); rd_reg(3'd4, v); check("R4 no re-fire above threshold", v & 32'h8, 0);
    @(negedge clk); pkt = 1'b1; wr = 1'b1; addr = 3'd4; wdata = 32'h04;
    @(negedge clk); pkt = 1'b0; wr = 1'b0;
    rd_reg(3'd4, v); check("R10 set wins over clear", v & 32'h4, 32'h4);
    drain();
    wr_reg(3'd2, 0); pulse(5); rd_reg(3'd4, v); check("R5 zero threshold", v & 32'h8, 0);
    drain();
  endtask

  task automatic t_wait();
    wr_reg(3'd3, 3);
    pulse(1); idle(11); rd_reg(3'd4, v); check("R7 wait not yet", v & 32'h10, 0);
    idle(1); rd_reg(3'd4, v); check("R7 wait fires at bound*prescale", v & 32'h10, 32'h10);
    drain();
    pulse(1); idle(8); pulse(1); idle(11); rd_reg(3'd4, v);
    check("R7 restart on packet", v & 32'h10, 0);
    idle(1); rd_reg(3'd4, v); check("R7 fires after restart", v & 32'h10, 32'h10);
    drain();
    pulse(1); idle(6); wr_reg(3'd1, 0); idle(20); rd_reg(3'd4, v);
    check("R9 timer stops at zero", v & 32'h10, 0);
    pulse(1); idle(11); rd_reg(3'd4, v); check("R9 fresh window early", v & 32'h10, 0);
    idle(1); rd_reg(3'd4, v); check("R9 fresh window fires", v & 32'h10, 32'h10);
    drain();
    wr_reg(3'd3, 0); pulse(1); idle(40); rd_reg(3'd4, v);
    check("R8 zero bound", v & 32'h10, 0);
    drain();
  endtask

  task automatic t_irq();
    wr_reg(3'd5, 32'hFF); rd_reg(3'd5, v); check("R11 enable layout", v, 32'h1C);
    wr_reg(3'd5, 32'h04);
    pulse(1); check("R11 irq on enabled bit", {31'b0, irq}, 1);
    wr_reg(3'd5, 32'h08); check("R11 irq masked", {31'b0, irq}, 0);
    wr_reg(3'd5, 32'h04); check("R11 irq unmasked", {31'b0, irq}, 1);
    wr_reg(3'd4, 32'h04); check("R10 irq drops after W1C", {31'b0, irq}, 0);
    drain(); wr_reg(3'd5, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    idle(3); rst_n = 1'b1; idle(1);
    t_reset();
    t_saturate();
    t_same_cycle();
    t_threshold();
    t_wait();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule